// File: doc/BRIEF.md
# Splittable Lookup-Table Logic Tile

This tile is one configurable logic cell of a programmable fabric. At its core is a 32-entry, single-bit lookup table held in writable configuration storage. In whole mode the five logic inputs address the table directly, so the tile realises any function of five variables. In split mode the table acts as two 16-entry halves. The lower half drives function F and the upper half drives function G. Each half takes three shared inputs and one fourth input chosen by configuration.

Two flip-flops on the tile clock capture F and G. Each output can show either the combinational function or its registered copy. The registered values can also serve as table inputs, which lets the tile build small state machines. Configuration goes through one single-bit port with a combinational readback. That port writes the table, the mode bit, the two output selectors and the two fourth-input selectors.

Top module: `cfg_lut_tile`

## Requirements
- R1: In whole mode, F and G both equal the table bit at index {E,D,C,B,A}, with lutIn[0]=A as the least significant address bit and lutIn[4]=E as the most significant.
- R2: A table holding 1 only at index 31 makes the combinational outputs the AND of all five inputs.
- R3: In whole mode, with both outputs set to combinational, xOut always equals yOut.
- R4: In split mode, F is the table bit at {0,s,C,B,A} and G is the bit at {1,t,C,B,A}. Here s and t are picked by the F and G selector codes: 0=D, 1=E, 2=Qx, 3=Qy.
- R5: On each rising clock edge, Qx captures F and Qy captures G.
- R6: xOut shows F when its route bit is 0 and Qx when it is 1. yOut shows G or Qy in the same way.
- R7: A write with cfgWe=1 updates the addressed bit from the next cycle on. The configuration address map is:
  - 0..31: table entries.
  - 32: split-mode bit.
  - 33: X route bit.
  - 34: Y route bit.
  - 35 and 36: F selector bits 0 and 1.
  - 37 and 38: G selector bits 0 and 1.
  cfgRData shows the bit at cfgAddr combinationally.
- R8: Active-low asynchronous reset clears the table, all configuration bits and both flip-flops, so both outputs read 0.
- R9: Writes to addresses 39..63 change nothing, and reads of those addresses return 0.
- R10: When a selector picks Qx or Qy, the half's address follows the registered value of the previous cycle. An entry chosen so that F copies the inverse of Qx therefore makes Qx toggle every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock shared by both flip-flops and configuration storage |
| rstN | input | 1 | Asynchronous active-low reset |
| lutIn | input | 5 | Logic inputs, bit 0 = A through bit 4 = E |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Configuration bit address |
| cfgWData | input | 1 | Configuration write bit |
| cfgRData | output | 1 | Configuration bit at cfgAddr |
| xOut | output | 1 | F or Qx, by route bit |
| yOut | output | 1 | G or Qy, by route bit |

## Verification
The bench drives random tables through every input pattern in whole mode. This exposes a reversed bit order or an off-by-one address, which would produce values that look plausible but sit in the wrong position. In split mode it walks all sixteen selector combinations, including Qx and Qy feedback. A tile that read the live next-state instead of the registered one would miss the toggle pattern, and a tile that used the wrong half would swap F and G. Writes past the mode bits are checked for leaking into the route or selector bits. A write to an address that is decoded too loosely would silently change the tile's function.

// File: rtl/lut_tile_pkg.sv
package lut_tile_pkg;

  typedef enum logic [1:0] {
    PICK_D  = 2'd0,
    PICK_E  = 2'd1,
    PICK_QX = 2'd2,
    PICK_QY = 2'd3
  } pick_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic tblWe;
    logic modeWe;
    logic wrBit;
  } cfg_strobe_t;

  // Decoded tile mode
  typedef struct packed {
    logic  split;
    logic  xReg;
    logic  yReg;
    pick_e fPick;
    pick_e gPick;
  } tile_mode_t;

  localparam int MODE_BITS = 7;

endpackage

// File: rtl/lut_tile_ctrl.sv
module lut_tile_ctrl
  import lut_tile_pkg::*;
#(
  parameter int IN_CNT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IN_CNT:0]   cfgAddr,
  input  logic              cfgWData,
  input  logic              tblBit,
  output logic              cfgRData,
  output cfg_strobe_t       strobe,
  output tile_mode_t        mode
);
  localparam int AW    = IN_CNT + 1;
  localparam int DEPTH = 1 << IN_CNT;

  logic [MODE_BITS-1:0] modeBits;
  logic [AW-1:0]        modeOff;
  logic                 isTbl;
  logic                 modeHit;

  assign isTbl   = (cfgAddr[AW-1] == 1'b0);
  assign modeOff = cfgAddr - AW'(DEPTH);
  assign modeHit = !isTbl && (modeOff < AW'(MODE_BITS));

  assign strobe.tblWe  = cfgWe && isTbl;
  assign strobe.modeWe = cfgWe && modeHit;
  assign strobe.wrBit  = cfgWData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBits <= '0;
    end else if (strobe.modeWe) begin
      modeBits[modeOff[2:0]] <= strobe.wrBit;
    end
  end

  assign mode.split = modeBits[0];
  assign mode.xReg  = modeBits[1];
  assign mode.yReg  = modeBits[2];
  assign mode.fPick = pick_e'(modeBits[4:3]);
  assign mode.gPick = pick_e'(modeBits[6:5]);

  always_comb begin
    if (isTbl)        cfgRData = tblBit;
    else if (modeHit) cfgRData = modeBits[modeOff[2:0]];
    else              cfgRData = 1'b0;
  end

  // R9: stray addresses leave the mode bits alone
  a_r9_stray_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !isTbl && !modeHit) |=> $stable(modeBits));

endmodule

// File: rtl/lut_tile_dp.sv
module lut_tile_dp
  import lut_tile_pkg::*;
#(
  parameter int IN_CNT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strobe,
  input  logic [IN_CNT-1:0] cfgIdx,
  input  tile_mode_t        mode,
  input  logic [IN_CNT-1:0] lutIn,
  output logic              tblBit,
  output logic              xOut,
  output logic              yOut
);
  localparam int DEPTH  = 1 << IN_CNT;
  localparam int SHARED = IN_CNT - 2;

  logic [DEPTH-1:0] tbl;
  logic             qx, qy;
  logic [1:0]       halfVal;
  logic             wholeVal, fVal, gVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tbl <= '0;
    end else if (strobe.tblWe) begin
      tbl[cfgIdx] <= strobe.wrBit;
    end
  end

  assign tblBit   = tbl[cfgIdx];
  assign wholeVal = tbl[lutIn];

  for (genvar h = 0; h < 2; h++) begin : g_half
    pick_e              code;
    logic               fourth;
    logic [IN_CNT-1:0]  idx;
    assign code = (h == 0) ? mode.fPick : mode.gPick;
    always_comb begin
      unique case (code)
        PICK_D:  fourth = lutIn[IN_CNT-2];
        PICK_E:  fourth = lutIn[IN_CNT-1];
        PICK_QX: fourth = qx;
        default: fourth = qy;
      endcase
    end
    assign idx        = {1'(h), fourth, lutIn[SHARED-1:0]};
    assign halfVal[h] = tbl[idx];
  end

  assign fVal = mode.split ? halfVal[0] : wholeVal;
  assign gVal = mode.split ? halfVal[1] : wholeVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qx <= 1'b0;
      qy <= 1'b0;
    end else begin
      qx <= fVal;
      qy <= gVal;
    end
  end

  assign xOut = mode.xReg ? qx : fVal;
  assign yOut = mode.yReg ? qy : gVal;

  // R3: one function feeds both outputs in whole mode
  a_r3_whole_outputs_agree: assert property (@(posedge clk) disable iff (!rstN)
    (!mode.split && !mode.xReg && !mode.yReg) |-> (xOut == yOut));

  // R5: both registers captured the same whole-mode value
  a_r5_regs_agree: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!mode.split) && mode.xReg && mode.yReg) |-> (xOut == yOut));

endmodule

// File: rtl/cfg_lut_tile.sv
module cfg_lut_tile
  import lut_tile_pkg::*;
#(
  parameter int IN_CNT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IN_CNT-1:0] lutIn,
  input  logic              cfgWe,
  input  logic [IN_CNT:0]   cfgAddr,
  input  logic              cfgWData,
  output logic              cfgRData,
  output logic              xOut,
  output logic              yOut
);
  localparam int DEPTH   = 1 << IN_CNT;
  localparam int CFG_TOP = DEPTH + MODE_BITS;

  cfg_strobe_t strobe;
  tile_mode_t  mode;
  logic        tblBit;

  lut_tile_ctrl #(.IN_CNT(IN_CNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWData(cfgWData), .tblBit(tblBit), .cfgRData(cfgRData),
    .strobe(strobe), .mode(mode)
  );

  lut_tile_dp #(.IN_CNT(IN_CNT)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgIdx(cfgAddr[IN_CNT-1:0]),
    .mode(mode), .lutIn(lutIn), .tblBit(tblBit), .xOut(xOut), .yOut(yOut)
  );

  // R7: a written bit reads back on the following cycle
  a_r7_write_readback: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && (int'(cfgAddr) < CFG_TOP)) |=>
      ((cfgAddr != $past(cfgAddr)) || (cfgRData == $past(cfgWData))));

endmodule

// File: tb/cfg_lut_tile_tb_top.sv
module cfg_lut_tile_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] lutIn = '0;
  logic       cfgWe = 1'b0;
  logic [5:0] cfgAddr = '0;
  logic       cfgWData = 1'b0;
  logic       cfgRData, xOut, yOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference state
  logic [31:0] mTbl = '0;
  logic        mSplit = 0, mX = 0, mY = 0;
  logic [1:0]  mFS = 0, mGS = 0;
  logic        mQx = 0, mQy = 0;

  always #10 clk = ~clk;

  cfg_lut_tile dut_i (
    .clk(clk), .rstN(rstN), .lutIn(lutIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWData(cfgWData), .cfgRData(cfgRData), .xOut(xOut), .yOut(yOut)
  );

  function automatic logic pickBit(logic [1:0] s, logic [4:0] v);
    case (s)
      2'd0: return v[3];
      2'd1: return v[4];
      2'd2: return mQx;
      default: return mQy;
    endcase
  endfunction

  function automatic logic fnF(logic [4:0] v);
    if (!mSplit) return mTbl[v];
    return mTbl[{1'b0, pickBit(mFS, v), v[2:0]}];
  endfunction

  function automatic logic fnG(logic [4:0] v);
    if (!mSplit) return mTbl[v];
    return mTbl[{1'b1, pickBit(mGS, v), v[2:0]}];
  endfunction

  function automatic logic cfgRead(logic [5:0] a);
    if (a < 32) return mTbl[a[4:0]];
    case (a)
      6'd32: return mSplit;
      6'd33: return mX;
      6'd34: return mY;
      6'd35: return mFS[0];
      6'd36: return mFS[1];
      6'd37: return mGS[0];
      6'd38: return mGS[1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock: drive at negedge, check, then advance the model
  task automatic step(string tag, logic [4:0] v, logic we, logic [5:0] a, logic d);
    logic eF, eG;
    @(negedge clk);
    lutIn = v; cfgWe = we; cfgAddr = a; cfgWData = d;
    #2;
    eF = fnF(v);
    eG = fnG(v);
    chk(tag, xOut, mX ? mQx : eF);
    chk(tag, yOut, mY ? mQy : eG);
    chk({tag, " rd"}, cfgRData, cfgRead(a));
    @(posedge clk);
    #1;
    mQx = eF;
    mQy = eG;
    if (we) begin
      if (a < 32) mTbl[a[4:0]] = d;
      else case (a)
        6'd32: mSplit = d;
        6'd33: mX = d;
        6'd34: mY = d;
        6'd35: mFS[0] = d;
        6'd36: mFS[1] = d;
        6'd37: mGS[0] = d;
        6'd38: mGS[1] = d;
        default: ;
      endcase
    end
  endtask

  task automatic setMode(logic sp, logic x, logic y, logic [1:0] fs, logic [1:0] gs);
    step("R7 mode", 5'd0, 1, 6'd32, sp);
    step("R7 mode", 5'd0, 1, 6'd33, x);
    step("R7 mode", 5'd0, 1, 6'd34, y);
    step("R7 mode", 5'd0, 1, 6'd35, fs[0]);
    step("R7 mode", 5'd0, 1, 6'd36, fs[1]);
    step("R7 mode", 5'd0, 1, 6'd37, gs[0]);
    step("R7 mode", 5'd0, 1, 6'd38, gs[1]);
  endtask

  task automatic loadTable(logic [31:0] t);
    for (int i = 0; i < 32; i++) step("R7 load", 5'(i), 1, 6'(i), t[i]);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #2;
    // R8: reset state
    chk("R8 reset x", xOut, 1'b0);
    chk("R8 reset y", yOut, 1'b0);
    chk("R8 reset rd", cfgRData, 1'b0);
    rstN = 1'b1;

    // R2: single entry 31 gives a five-input AND
    loadTable(32'h8000_0000);
    for (int v = 0; v < 32; v++) step("R2 and5", 5'(v), 0, 6'(v), 0);

    // R1 R3 R5 R6: random tables in whole mode, all routes
    for (int r = 0; r < 4; r++) begin
      loadTable($urandom());
      setMode(0, r[0], r[1], 2'($urandom()), 2'($urandom()));
      for (int v = 0; v < 32; v++) step("R1 whole", 5'(v), 0, 6'($urandom_range(0, 38)), 0);
      for (int k = 0; k < 20; k++) step("R6 route", 5'($urandom()), 0, 6'($urandom()), 0);
    end

    // R4 R10: split mode with every selector pair
    for (int s = 0; s < 16; s++) begin
      loadTable($urandom());
      setMode(1, s[0], s[2], 2'(s), 2'(s >> 2));
      for (int k = 0; k < 24; k++) step("R4 split", 5'($urandom()), 0, 6'($urandom_range(0, 38)), 0);
    end

    // R10: F = ~Qx toggles Qx every cycle (entries with fourth bit Qx=0 set to 1)
    loadTable(32'h0000_00FF);
    setMode(1, 1, 0, 2'd2, 2'd0);
    for (int k = 0; k < 12; k++) step("R10 toggle", 5'($urandom()), 0, 6'd0, 0);

    // R9: stray writes ignored, stray reads return 0
    for (int a = 39; a < 64; a++) step("R9 stray", 5'($urandom()), 1, 6'(a), 1);
    for (int a = 32; a < 39; a++) step("R9 modes kept", 5'($urandom()), 0, 6'(a), 0);
    for (int k = 0; k < 10; k++) step("R9 after", 5'($urandom()), 0, 6'($urandom_range(39, 63)), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule